// File: doc/BRIEF.md
# Receive Shadow Queue with RTS Hysteresis

This block sits on the receive path between the character deserializer and the software-visible receive FIFO. Every byte the deserializer delivers goes into a small shadow queue. That queue empties itself into the downstream FIFO whenever the downstream side reports room. Each cycle it can push at most one byte, and it always pushes the oldest one. Nothing waits for software.

The block also drives the request-to-send pin, which throttles the far-end transmitter. In automatic mode the pin goes inactive (high) once the shadow queue is nearly full. It becomes active (low) again only after the queue has drained completely. This gap between the release point and the re-arm point stops the pin from chattering around one level. The byte slots above the threshold give the far end time to stop sending. In manual mode the pin simply mirrors a control bit.

A byte that arrives while the queue is full and nothing leaves in that cycle is lost. The loss raises a sticky overflow flag.

Top module: `rxq_flow_ctrl`

## Requirements
- R1: Automatic throttling is in effect only while `auto_rts_en` is 1 and `manual_rts` is 0. With `auto_rts_en`=1 and `manual_rts`=1 the pin is driven high.
- R2: While automatic throttling is in effect, `rts_n` is 1 in every cycle in which the queue holds at least THRESH bytes (default 28).
- R3: Once `rts_n` has gone high under automatic throttling, it stays high while the queue holds any byte. It returns to 0 in the same cycle the queue becomes empty.
- R4: `out_valid` is 1 exactly when `user_space` is 1 and the queue is not empty. `out_data` then carries the oldest stored byte, and that byte leaves the queue at the clock edge.
- R5: The queue holds DEPTH bytes (default 32) and delivers them in arrival order.
- R6: A byte offered with `in_valid` while the queue holds DEPTH bytes and `out_valid` is 0 is discarded. In that case `ovf_flag` reads 1 from the next cycle on and stays 1 until a cycle with `ovf_clr`=1. A byte offered at full in a cycle with `out_valid`=1 is accepted and raises no overflow.
- R7: A cycle that both stores and delivers a byte leaves the number of stored bytes unchanged.
- R8: While automatic throttling is not in effect, `rts_n` equals `manual_rts` in the same cycle, whatever the fill level.
- R9: Reset (`rst_n`=0) empties the queue and clears `ovf_flag`. With `auto_rts_en`=1 and `manual_rts`=0, `rts_n` is 0 during and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Received byte from the deserializer |
| in_valid | input | 1 | `in_data` is valid this cycle |
| user_space | input | 1 | Downstream FIFO can take a byte this cycle |
| auto_rts_en | input | 1 | Enable automatic RTS throttling |
| manual_rts | input | 1 | Manual RTS pin level; must be 0 for automatic mode |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rts_n | output | 1 | Request-to-send pin, low = far end may send |
| out_data | output | DATA_W | Oldest stored byte, pushed downstream |
| out_valid | output | 1 | Push strobe toward the downstream FIFO |
| ovf_flag | output | 1 | Sticky flag: a byte was discarded |

## Verification
The hardest state to reach is the middle of the hysteresis band while the queue is draining. The pin must stay high even though the fill level is well below the threshold. That state can only be reached by first filling past the threshold while downstream space is withheld, and only then releasing it. The stimulus therefore sweeps the fill level upward one byte per cycle with `user_space` low, up to and past full. It then drains one byte per cycle and checks the pin and the delivered byte at every level. A second run stops partway down the drain, refills below the threshold and drains again. Further runs hold the queue full while a byte leaves and another arrives in the same cycle, and stream traffic with concurrent writes and reads at a constant level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic {
      RTS_OPEN = 1'b0,
      RTS_HELD = 1'b1
   } rts_state_e;

   function automatic int unsigned cnt_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW-1:0] ptr
);

   logic [AW-1:0] ptr_nxt;

   generate
      if ((2 ** AW) == DEPTH) begin : g_pow2_wrap
         assign ptr_nxt = ptr + AW'(1);
      end else begin : g_cmp_wrap
         assign ptr_nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr_nxt;
   end

endmodule

// File: rtl/rxq_shadow_fifo.sv
module rxq_shadow_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = rxq_pkg::cnt_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     fill,
   output logic              full,
   output logic              empty
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;

   rxq_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (wr_en),
      .ptr   (wr_ptr)
   );

   rxq_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (rd_en),
      .ptr   (rd_ptr)
   );

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else begin
         unique case ({wr_en, rd_en})
            2'b10:   fill <= fill + CW'(1);
            2'b01:   fill <= fill - CW'(1);
            default: fill <= fill;
         endcase
      end
   end

   assign full  = (fill == CW'(DEPTH));
   assign empty = (fill == '0);

endmodule

// File: rtl/rxq_rts_ctl.sv
module rxq_rts_ctl #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 28,
   localparam int unsigned CW = rxq_pkg::cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          auto_act,
   input  logic          manual_rts,
   input  logic [CW-1:0] fill,
   output logic          rts_n
);

   import rxq_pkg::*;

   rts_state_e state_q;
   rts_state_e state_d;
   logic       at_thr;
   logic       drained;
   logic       held_now;

   assign at_thr   = (fill >= CW'(THRESH));
   assign drained  = (fill == '0);
   assign held_now = at_thr | ((state_q == RTS_HELD) & ~drained);
   assign state_d  = (auto_act & held_now) ? RTS_HELD : RTS_OPEN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RTS_OPEN;
      else        state_q <= state_d;
   end

   assign rts_n = auto_act ? held_now : manual_rts;

endmodule

// File: rtl/rxq_flow_ctrl.sv
module rxq_flow_ctrl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              user_space,
   input  logic              auto_rts_en,
   input  logic              manual_rts,
   input  logic              ovf_clr,
   output logic              rts_n,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              ovf_flag
);

   localparam int unsigned CW = rxq_pkg::cnt_width(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $fatal(1, "rxq_flow_ctrl: DEPTH must be at least 2");
      end
      if (THRESH == 0 || THRESH > DEPTH) begin : g_bad_thresh
         $fatal(1, "rxq_flow_ctrl: THRESH must lie in 1..DEPTH");
      end
      if (DATA_W == 0) begin : g_bad_width
         $fatal(1, "rxq_flow_ctrl: DATA_W must be nonzero");
      end
   endgenerate

   logic          auto_act;
   logic          pop;
   logic          push;
   logic          drop;
   logic          q_full;
   logic          q_empty;
   logic [CW-1:0] fill_lvl;

   assign auto_act = auto_rts_en & ~manual_rts;
   assign pop      = user_space & ~q_empty;
   assign push     = in_valid & (~q_full | pop);
   assign drop     = in_valid & q_full & ~pop;

   rxq_shadow_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push),
      .wr_data (in_data),
      .rd_en   (pop),
      .rd_data (out_data),
      .fill    (fill_lvl),
      .full    (q_full),
      .empty   (q_empty)
   );

   rxq_rts_ctl #(
      .DEPTH  (DEPTH),
      .THRESH (THRESH)
   ) u_rts (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_act   (auto_act),
      .manual_rts (manual_rts),
      .fill       (fill_lvl),
      .rts_n      (rts_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (drop)    ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

   assign out_valid = pop;

endmodule

// File: rtl/rxq_flow_ctrl_chk.sv
module rxq_flow_ctrl_chk #(
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned THRESH = 28,
   localparam int unsigned CW = rxq_pkg::cnt_width(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          user_space,
   input logic          auto_rts_en,
   input logic          manual_rts,
   input logic          ovf_clr,
   input logic          rts_n,
   input logic          out_valid,
   input logic          ovf_flag,
   input logic [CW-1:0] fill_lvl
);

   logic auto_on;
   assign auto_on = auto_rts_en & ~manual_rts;

   p_rts_at_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && fill_lvl >= CW'(THRESH)) |-> rts_n);

   p_rts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && $past(auto_on) && $past(rts_n) && fill_lvl != '0) |-> rts_n);

   p_rts_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_on && fill_lvl == '0) |-> !rts_n);

   p_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!user_space || fill_lvl == '0) |-> !out_valid);

   p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_lvl <= CW'(DEPTH));

   p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fill_lvl == CW'(DEPTH) && !out_valid) |=> ovf_flag);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);

   p_level_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && out_valid) |=> fill_lvl == $past(fill_lvl));

   p_manual_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_rts_en |-> (rts_n == manual_rts));

   p_reset_pin_r9: assert property (@(posedge clk)
      (!rst_n && auto_on) |-> !rts_n);

endmodule

bind rxq_flow_ctrl rxq_flow_ctrl_chk #(
   .DEPTH  (DEPTH),
   .THRESH (THRESH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .user_space  (user_space),
   .auto_rts_en (auto_rts_en),
   .manual_rts  (manual_rts),
   .ovf_clr     (ovf_clr),
   .rts_n       (rts_n),
   .out_valid   (out_valid),
   .ovf_flag    (ovf_flag),
   .fill_lvl    (fill_lvl)
);

// File: tb/rxq_flow_ctrl_tb.sv
module rxq_flow_ctrl_tb;

   localparam int DEPTH  = 32;
   localparam int THRESH = 28;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       user_space = 1'b0;
   logic       auto_rts_en = 1'b1;
   logic       manual_rts = 1'b0;
   logic       ovf_clr = 1'b0;
   logic       rts_n;
   logic [7:0] out_data;
   logic       out_valid;
   logic       ovf_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rxq_flow_ctrl #(.DATA_W(8), .DEPTH(DEPTH), .THRESH(THRESH)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_data     (in_data),
      .in_valid    (in_valid),
      .user_space  (user_space),
      .auto_rts_en (auto_rts_en),
      .manual_rts  (manual_rts),
      .ovf_clr     (ovf_clr),
      .rts_n       (rts_n),
      .out_data    (out_data),
      .out_valid   (out_valid),
      .ovf_flag    (ovf_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One clock: drive inputs, sample the combinational push, cross the edge.
   task automatic beat(input bit v, input int d, input bit sp, input bit clr,
                       output bit ov, output int od);
      in_valid   = v;
      in_data    = 8'(d);
      user_space = sp;
      ovf_clr    = clr;
      #1;
      ov = out_valid;
      od = int'(out_data);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      ovf_clr  = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit ov;
      int od;

      // R9: reset state with automatic control enabled, downstream ready.
      user_space = 1'b1;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R9 rts during reset", rts_n, 0);
      chk("R9 no push during reset", out_valid, 0);
      chk("R9 flag clear in reset", ovf_flag, 0);
      rst_n = 1'b1;
      #1;
      chk("R9 empty after reset", out_valid, 0);
      user_space = 1'b0;

      // Fill sweep 1..DEPTH+1 with no downstream space: R2, R4, R6.
      for (int i = 1; i <= DEPTH + 1; i++) begin
         int lvl;
         beat(1, i, 0, 0, ov, od);
         lvl = (i > DEPTH) ? DEPTH : i;
         chk("R4 no push without space", ov, 0);
         chk("R2 rts vs level", rts_n, (lvl >= THRESH) ? 1 : 0);
         chk("R6 overflow flag", ovf_flag, (i > DEPTH) ? 1 : 0);
      end

      // Drain sweep: order R5, hysteresis R3.
      for (int k = 1; k <= DEPTH; k++) begin
         beat(0, 0, 1, 0, ov, od);
         chk("R4 push with space", ov, 1);
         chk("R5 drain order", od, k);
         chk("R3 rts held until empty", rts_n, (k < DEPTH) ? 1 : 0);
      end
      beat(0, 0, 1, 0, ov, od);
      chk("R4 no push when empty", ov, 0);
      chk("R6 flag sticky", ovf_flag, 1);
      beat(0, 0, 0, 1, ov, od);
      chk("R6 flag cleared", ovf_flag, 0);

      // Concurrent traffic at a steady level of 5: R7.
      for (int i = 0; i < 5; i++) beat(1, 100 + i, 0, 0, ov, od);
      for (int j = 0; j < 40; j++) begin
         beat(1, 105 + j, 1, 0, ov, od);
         chk("R7 stream order", od, 100 + j);
         chk("R7 level steady rts low", rts_n, 0);
      end
      for (int j = 0; j < 5; j++) begin
         beat(0, 0, 1, 0, ov, od);
         chk("R7 residual byte", od, 140 + j);
      end
      beat(0, 0, 1, 0, ov, od);
      chk("R7 exactly five left", ov, 0);

      // Full queue with a same-cycle pop: R6 acceptance.
      for (int i = 0; i < DEPTH; i++) beat(1, i, 0, 0, ov, od);
      chk("R2 full rts", rts_n, 1);
      beat(1, 77, 1, 0, ov, od);
      chk("R6 pop at full", od, 0);
      chk("R6 no overflow with pop", ovf_flag, 0);
      for (int k = 1; k <= DEPTH; k++) begin
         beat(0, 0, 1, 0, ov, od);
         chk("R5 order after full", od, (k < DEPTH) ? k : 77);
      end
      chk("R3 release at empty", rts_n, 0);

      // Partial hysteresis: up to 28, down to 10, up to 15, down to 0.
      for (int i = 0; i < THRESH; i++) beat(1, i, 0, 0, ov, od);
      chk("R2 at threshold", rts_n, 1);
      for (int i = 0; i < 18; i++) beat(0, 0, 1, 0, ov, od);
      chk("R3 held at level 10", rts_n, 1);
      for (int i = 0; i < 5; i++) beat(1, i, 0, 0, ov, od);
      chk("R3 held at level 15", rts_n, 1);
      for (int i = 0; i < 14; i++) beat(0, 0, 1, 0, ov, od);
      chk("R3 held at level 1", rts_n, 1);
      beat(0, 0, 1, 0, ov, od);
      chk("R3 low at level 0", rts_n, 0);

      // Manual mode with the queue above threshold: R8, R1.
      auto_rts_en = 1'b0;
      for (int i = 0; i < 30; i++) beat(1, i, 0, 0, ov, od);
      manual_rts = 1'b0; #1;
      chk("R8 manual low at level 30", rts_n, 0);
      manual_rts = 1'b1; #1;
      chk("R8 manual high", rts_n, 1);
      auto_rts_en = 1'b1; #1;
      chk("R1 manual bit overrides", rts_n, 1);
      manual_rts = 1'b0; #1;
      chk("R1 auto engages at level 30", rts_n, 1);

      // Reset while loaded: R9.
      user_space = 1'b1;
      rst_n = 1'b0; #1;
      chk("R9 rts low in reset", rts_n, 0);
      do_reset();
      chk("R9 queue empty after reset", out_valid, 0);
      chk("R9 rts low after reset", rts_n, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule